// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between a simple on-chip request port and an external asynchronous static RAM with 32K byte locations, a shared data bus and three active-low strobes (select, output enable, write enable). A client presents one read or write at a time with a 15-bit address and, for writes, an 8-bit datum. The controller sequences the strobes in whole clock cycles and returns read data with a one-cycle completion pulse.

Every duration is specified in nanoseconds and converted to cycles at elaboration from the clock period parameter. Each duration is rounded up, with at least one cycle per phase. The shared bus is split into an output value, a driver enable and an input value, so the pad's tri-state buffer sits outside the block. A read always ends with a bus-release wait before the next request is taken, so the controller can never drive the bus while the RAM may still be driving it.

Top module: `asram_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, select, output enable and write enable are high (inactive), the data driver enable is 0, and busy and done are 0.
- R2: A request is taken only while busy is 0. busy is 1 from the cycle after acceptance up to and including the done cycle, and 0 in the cycle after done. A request raised while busy is 1 has no effect on the RAM contents.
- R3: A read lowers select and output enable together, with write enable high. Both stay low for ACC = max(ceil(70/T), ceil(35/T)) cycles. The bus is sampled at the end of that window, and the sampled byte is presented on rdata while done is 1.
- R4: A write holds select low with write enable high for one cycle. Write enable is then low for WP = max(ceil(55/T), ceil(30/T), ceil(60/T)-1) cycles. Output enable stays high for the whole write, so select and address are valid at least 60 ns before write enable rises.
- R5: The driver enable is 1 exactly while write enable is low, and the write datum is on the bus from the cycle write enable falls. The datum is therefore stable at least 30 ns before write enable rises, and it is released when write enable rises.
- R6: A write reports done in cycle 1 + WP + REC after acceptance, where REC = max(1, ceil(70/T) - 1 - WP). This keeps the write cycle at or above 70 ns.
- R7: A read reports done in cycle ACC + 1 + TA after acceptance, where TA = max(ceil(30/T), ceil(70/T) - ACC - 1). The strobes are released in the cycle after sampling.
- R8: The RAM address does not change while select stays low.
- R9: The controller never enables its driver while output enable is low, or within 30 ns after the RAM stops driving.
- R10: done is high for exactly one cycle per request.

Here T is CLK_PERIOD_NS and ceil(x/T) is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Byte address |
| req_wdata | input | DATA_W (8) | Write datum |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (8) | Read result, valid with done |
| ram_addr | output | ADDR_W (15) | RAM address pins |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | DATA_W (8) | Value for the bus driver |
| ram_dq_oe | output | 1 | Bus driver enable |
| ram_dq_in | input | DATA_W (8) | Value seen on the bus |

## Verification
The embedded properties are checked on every cycle. They cover the strobe combinations: no driving while output enable is low, output enable high during write, and the driver following the write-enable fall. They also cover address hold under select, the one-cycle done pulse, the minimum write-enable width, and the release gap before driving, the last two counted in cycles. What these cycle counts mean in nanoseconds only shows in the bench: a timing-aware RAM model returns corrupted data for an early sample, checks the write pulse, setup and data windows against absolute time, and flags any overlap with the RAM's release window. Exact completion latencies and the harmlessness of requests raised mid-transfer can only be seen through the bench's read-back sweeps.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the static RAM port controller.
// Assumes all durations are given as positive nanosecond integers.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } seq_state_t;

    // Converts a duration to whole cycles, rounding up, never below one.
    function automatic int ns_to_cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one sequencer phase.
// Loading a length N makes 'last' high in the N-th cycle after the load edge.
// Assumes the sequencer reloads on every state change and never loads zero.
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Count the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_len - 1'b1;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    // R6: every phase lasts at least one cycle
    a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));

endmodule

// File: rtl/asram_sequencer.sv
`timescale 1ns/1ps
// Transfer state machine. It walks each request through its phases and
// registers the RAM strobes and driver enable from the next state, so the
// pins change only on clock edges. Assumes a phase timer reporting 'tm_last'.
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RW_CYC  = 8,
    parameter int TA_CYC  = 4,
    parameter int WP_CYC  = 7,
    parameter int REC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tm_last,
    output logic             tm_load,
    output logic [CNT_W-1:0] tm_len,
    output logic             accept,
    output logic             capture,
    output logic             done,
    output logic             busy,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             drv_en
);

    seq_state_t st, nx;

    // Choose the next phase when the current one has run out.
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:       if (req_valid) nx = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            ST_RD_SETUP:   if (tm_last)   nx = ST_RD_WAIT;
            ST_RD_WAIT:    if (tm_last)   nx = ST_RD_CAPTURE;
            ST_RD_CAPTURE: if (tm_last)   nx = ST_TURNAROUND;
            ST_TURNAROUND: if (tm_last)   nx = ST_IDLE;
            ST_WR_SETUP:   if (tm_last)   nx = ST_WR_PULSE;
            ST_WR_PULSE:   if (tm_last)   nx = ST_WR_RECOVER;
            ST_WR_RECOVER: if (tm_last)   nx = ST_IDLE;
            default:                      nx = ST_IDLE;
        endcase
    end

    // Pick the length of the phase being entered.
    always_comb begin
        unique case (nx)
            ST_RD_WAIT:    tm_len = CNT_W'(RW_CYC);
            ST_TURNAROUND: tm_len = CNT_W'(TA_CYC);
            ST_WR_PULSE:   tm_len = CNT_W'(WP_CYC);
            ST_WR_RECOVER: tm_len = CNT_W'(REC_CYC);
            default:       tm_len = CNT_W'(1);
        endcase
    end

    assign tm_load = (nx != st);
    assign accept  = (st == ST_IDLE) && req_valid;
    assign capture = (st == ST_RD_WAIT) && tm_last;
    assign done    = tm_last && ((st == ST_TURNAROUND) || (st == ST_WR_RECOVER));
    assign busy    = (st != ST_IDLE);

    // Advance the state and register the pin strobes for the new state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cs_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            drv_en <= 1'b0;
        end else begin
            st     <= nx;
            cs_n   <= !(nx == ST_RD_SETUP || nx == ST_RD_WAIT ||
                        nx == ST_WR_SETUP || nx == ST_WR_PULSE);
            oe_n   <= !(nx == ST_RD_SETUP || nx == ST_RD_WAIT);
            we_n   <= !(nx == ST_WR_PULSE);
            drv_en <= (nx == ST_WR_PULSE);
        end
    end

    // Checking aids: cycles write enable has been low, cycles since output enable rose.
    int we_low_cnt;
    int rel_cnt;

    // Saturating interval counters used only by the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= 0;
            rel_cnt    <= TA_CYC;
        end else begin
            if (we_n)                      we_low_cnt <= 0;
            else if (we_low_cnt < WP_CYC)  we_low_cnt <= we_low_cnt + 1;
            if (!oe_n)                     rel_cnt <= 0;
            else if (rel_cnt < TA_CYC)     rel_cnt <= rel_cnt + 1;
        end
    end

    // R4: the write pulse is never shorter than its cycle count
    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_cnt >= WP_CYC));

    // R9: the driver turns on only after the float window has elapsed
    a_r9_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> (rel_cnt >= TA_CYC));

    // R5: the datum goes on the bus as write enable falls
    a_r5_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> drv_en);

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
// Address, write-data and read-data registers.
// Address and datum are captured on acceptance and held until the next
// acceptance. The bus is sampled into rdata on the sequencer's capture strobe.
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic [DATA_W-1:0] rdata
);

    // Hold the request's address and datum for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            ram_dq_out <= '0;
        end else if (accept) begin
            ram_addr   <= req_addr;
            ram_dq_out <= req_wdata;
        end
    end

    // Sample the bus at the end of the read access window.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (capture)  rdata <= ram_dq_in;
    end

endmodule

// File: rtl/asram_port_ctrl.sv
`timescale 1ns/1ps
// Top of the static RAM port controller. It converts the nanosecond limits
// to cycle counts and connects the timer, sequencer and datapath.
// Assumes one outstanding request and an external tri-state pad on the bus.
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int RD_CYCLE_NS   = 70,
    parameter int RD_ACCESS_NS  = 70,
    parameter int OE_ACCESS_NS  = 35,
    parameter int FLOAT_NS      = 30,
    parameter int WR_CYCLE_NS   = 70,
    parameter int WE_PULSE_NS   = 55,
    parameter int SEL_TO_END_NS = 60,
    parameter int DATA_SETUP_NS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int ACC_CYC = imax(ns_to_cyc(RD_ACCESS_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(OE_ACCESS_NS, CLK_PERIOD_NS));
    localparam int RW_CYC  = imax(1, ACC_CYC - 1);
    localparam int TA_CYC  = imax(ns_to_cyc(FLOAT_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(RD_CYCLE_NS, CLK_PERIOD_NS) - RW_CYC - 2);
    localparam int WP_CYC  = imax(imax(ns_to_cyc(WE_PULSE_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS)),
                                  ns_to_cyc(SEL_TO_END_NS, CLK_PERIOD_NS) - 1);
    localparam int REC_CYC = imax(1, ns_to_cyc(WR_CYCLE_NS, CLK_PERIOD_NS) - 1 - WP_CYC);
    localparam int MAX_LEN = imax(imax(RW_CYC, TA_CYC), imax(WP_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             tm_load;
    logic [CNT_W-1:0] tm_len;
    logic             tm_last;
    logic             accept;
    logic             capture;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_len (tm_len),
        .last     (tm_last)
    );

    asram_sequencer #(
        .CNT_W   (CNT_W),
        .RW_CYC  (RW_CYC),
        .TA_CYC  (TA_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tm_last   (tm_last),
        .tm_load   (tm_load),
        .tm_len    (tm_len),
        .accept    (accept),
        .capture   (capture),
        .done      (done),
        .busy      (busy),
        .cs_n      (ram_cs_n),
        .oe_n      (ram_oe_n),
        .we_n      (ram_we_n),
        .drv_en    (ram_dq_oe)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ram_dq_in  (ram_dq_in),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .rdata      (rdata)
    );

    // R8: address held while the RAM stays selected
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

    // R9: never drive while the RAM output is enabled
    a_r9_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> !ram_dq_oe);

    // R4: output enable stays high throughout a write pulse
    a_r4_oe_high_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (ram_oe_n && !ram_cs_n));

    // R3: a read strobe is always qualified by select with write enable high
    a_r3_read_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_cs_n && ram_we_n));

    // R10: completion pulse lasts one cycle
    a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done only appears inside a busy transfer
    a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/asram_port_ctrl_test.sv
`timescale 1ns/1ps
// Bench: a timing-aware RAM model polled every nanosecond, plus write/read-back
// sweeps with arithmetic expected data and latencies.
module asram_port_ctrl_test;

    localparam int PER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [14:0] ram_addr;
    logic        ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in = '0;

    int nchk = 0;
    int nerr = 0;
    bit model_on = 1'b0;

    asram_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    always #(PER/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected cycle counts, from the requirement formulas.
    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int E_ACC = (cyc(70) > cyc(35)) ? cyc(70) : cyc(35);
    int e_ta, e_wp, e_rec, rd_lat, wr_lat;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 7) ^ 8'h5C);
    endfunction

    // Behavioural RAM model with absolute-time checks.
    logic [7:0] mem [int];
    function automatic logic [7:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    initial begin
        realtime now, t_cs, t_oe, t_we, t_addr, t_dq, t_float;
        bit p_cs, p_oe, p_we, p_dqoe, p_rdrv, cs, oe, we, rdrv;
        logic [14:0] p_addr;
        logic [7:0]  p_dq;
        t_cs = 0; t_oe = 0; t_we = 0; t_addr = 0; t_dq = 0; t_float = -1000;
        p_cs = 1; p_oe = 1; p_we = 1; p_dqoe = 0; p_rdrv = 0; p_addr = '0; p_dq = '0;
        #0.25;
        forever begin
            now  = $realtime;
            cs   = ram_cs_n; oe = ram_oe_n; we = ram_we_n;
            rdrv = !cs && !oe && we;
            if (model_on) begin
                if (p_cs && !cs) t_cs = now;
                if (p_oe && !oe) t_oe = now;
                if (p_we && !we) t_we = now;
                if (ram_addr != p_addr) begin
                    t_addr = now;
                    if (!cs && !p_cs) check(1'b0, "R8", int'(ram_addr), int'(p_addr));
                end
                if (ram_dq_oe && (!p_dqoe || ram_dq_out != p_dq)) t_dq = now;
                if (!p_we && we) begin
                    check(now - t_we >= 55, "R4", int'(now - t_we), 55);
                    check(!p_cs && (now - t_cs >= 60) && (now - t_addr >= 60),
                          "R4", int'(now - t_cs), 60);
                    check(p_dqoe && (now - t_dq >= 30), "R5", int'(now - t_dq), 30);
                    mem[int'(p_addr)] = p_dq;
                end
                if (!we && !oe) check(1'b0, "R4", 0, 1);
                if (!we && !ram_dq_oe) check(1'b0, "R5", 0, 1);
                if (p_rdrv && !rdrv) t_float = now + 30;
                if (ram_dq_oe && (rdrv || now < t_float)) check(1'b0, "R9", 1, 0);
            end
            if (rdrv)
                ram_dq_in = ((now - t_cs >= 70) && (now - t_oe >= 35) && (now - t_addr >= 70))
                            ? mem_rd(int'(ram_addr)) : ~mem_rd(int'(ram_addr));
            else
                ram_dq_in = 8'h00;
            p_cs = cs; p_oe = oe; p_we = we; p_rdrv = rdrv;
            p_dqoe = ram_dq_oe; p_addr = ram_addr; p_dq = ram_dq_out;
            #1;
        end
    end

    // One transfer; optional intruding request mid-flight.
    task automatic xfer(input bit wr, input int a, input logic [7:0] d, input bit intrude,
                        output logic [7:0] rd, output int n);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 15'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; n = 1;
        check(busy == 1'b1, "R2", int'(busy), 1);
        while (!done && n < 100) begin
            if (intrude && n == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 15'(a ^ 1); req_wdata = ~d;
            end else if (n == 4) begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        rd = rdata;
        check(busy == 1'b1, "R2", int'(busy), 1);
        @(negedge clk);
        check(done == 1'b0, "R10", int'(done), 0);
        check(busy == 1'b0, "R2", int'(busy), 0);
    endtask

    task automatic wr(input int a, input logic [7:0] d, input bit intrude);
        logic [7:0] rd;
        int n;
        xfer(1'b1, a, d, intrude, rd, n);
        check(n == wr_lat, "R6", n, wr_lat);
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input bit intrude);
        logic [7:0] rd;
        int n;
        xfer(1'b0, a, 8'h00, intrude, rd, n);
        check(rd == e, "R3", int'(rd), int'(e));
        check(n == rd_lat, "R7", n, rd_lat);
    endtask

    initial begin
        int hi [4];
        e_ta   = mx(cyc(30), cyc(70) - E_ACC - 1);
        e_wp   = mx(mx(cyc(55), cyc(30)), cyc(60) - 1);
        e_rec  = mx(1, cyc(70) - 1 - e_wp);
        rd_lat = E_ACC + 1 + e_ta;
        wr_lat = 1 + e_wp + e_rec;
        hi[0] = 32'h7FFF; hi[1] = 32'h4000; hi[2] = 32'h2AAA; hi[3] = 32'h5555;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(ram_cs_n && ram_oe_n && ram_we_n, "R1",
              int'({ram_cs_n, ram_oe_n, ram_we_n}), 7);
        check(!ram_dq_oe && !busy && !done, "R1",
              int'({ram_dq_oe, busy, done}), 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // Low-address sweep write then read-back (R3, R6, R7).
        for (int a = 0; a < 256; a++) wr(a, pat(a), 1'b0);
        for (int i = 0; i < 4; i++) wr(hi[i], pat(hi[i]), 1'b0);
        for (int a = 0; a < 256; a++) rd_chk(a, pat(a), 1'b0);
        for (int i = 0; i < 4; i++) rd_chk(hi[i], pat(hi[i]), 1'b0);

        // Interleaved write-after-read turnaround with new data (R9).
        for (int a = 0; a < 32; a++) begin
            rd_chk(a, pat(a), 1'b0);
            wr(a, ~pat(a), 1'b0);
            rd_chk(a, ~pat(a), 1'b0);
        end

        // R2: requests raised while busy leave the neighbour untouched.
        wr(300, 8'h3C, 1'b1);
        rd_chk(301, 8'h00, 1'b0);
        rd_chk(300, 8'h3C, 1'b0);
        rd_chk(40, pat(40), 1'b1);
        rd_chk(41, pat(41), 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * PER);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule